// File: doc/BRIEF.md
# Two-Digit Decimal Adder with Seven-Segment Outputs

This block adds two packed decimal operands of two digits each, plus a single carry-in bit. It returns a three-digit packed decimal sum. Every operand digit and every sum digit is also decoded into an active-low seven-segment pattern. The block is purely combinational. It is built from continuous assignments and instances only: there are no procedural if statements, no procedural loops and no storage.

Each digit position is a cell that holds two structural 4-bit ripple-carry adders made of full-adder stages:

- The first adder forms the 5-bit binary total of the two digits and the incoming carry.
- When that total is above nine, the second adder adds six to its low four bits, which is the same as subtracting ten within the nibble. The cell then passes a carry to the next digit.

The lowest cell takes the external carry-in. The carry out of the highest cell becomes the top sum digit.

A single flag goes high whenever any operand nibble holds a code from ten to fifteen. While that flag is high, the sum outputs are not specified. The operand displays show an invalid nibble as a dark digit.

Top module: `bcd_sum_display`

## Requirements
- R1: The low sum digit `sum_bcd[3:0]` equals (A0 + B0 + carry_in) mod 10. Here A0 = `a_bcd[3:0]` and B0 = `b_bcd[3:0]`. A carry enters the high digit exactly when that total is 10 or more.
- R2: The middle sum digit `sum_bcd[7:4]` equals (A1 + B1 + c1) mod 10, where A1 = `a_bcd[7:4]`, B1 = `b_bcd[7:4]` and c1 is the low digit's carry. The top digit `sum_bcd[11:8]` is 1 when A1 + B1 + c1 is 10 or more, and 0 otherwise.
- R3: For every pair of valid operands and both carry-in values, the decimal value of `sum_bcd` equals the decimal value of A, plus that of B, plus carry_in. Every sum digit stays in 0..9. The extreme case 99 + 99 + 1 gives digits 1, 9, 9.
- R4: `digit_err` is 1 exactly when at least one of the four operand nibbles is greater than 9. A value of 9 in a nibble does not raise it.
- R5: Each seven-segment field is 7 bits, with bit 6 = g down to bit 0 = a, and a 0 lights a segment. The codes for digits 0..9 are 0x40, 0x79, 0x24, 0x30, 0x19, 0x12, 0x02, 0x78, 0x00 and 0x10.
- R6: The operand display fields are laid out in 7-bit slices of `seg_opnd`, from the lowest slice upward: A0, A1, B0, B1. A nibble above 9 shows 0x7F, which leaves every segment dark.
- R7: The sum display fields are laid out in 7-bit slices of `seg_sum`, from the lowest slice upward: S0, S1, S2. Each slice shows its sum digit in the R5 coding.
- R8: With all operands zero and carry_in 0, the sum is 000, `digit_err` is 0 and every display shows the digit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_bcd | input | 8 | First operand, two packed decimal digits, low digit in bits 3:0 |
| b_bcd | input | 8 | Second operand, two packed decimal digits, low digit in bits 3:0 |
| carry_in | input | 1 | Carry into the lowest digit |
| sum_bcd | output | 12 | Three-digit packed decimal sum, low digit in bits 3:0 |
| digit_err | output | 1 | High when any operand nibble is above 9 |
| seg_opnd | output | 28 | Active-low segment patterns for A0, A1, B0, B1 |
| seg_sum | output | 21 | Active-low segment patterns for S0, S1, S2 |

## Verification
The assertions on digit range and decimal value assume that every operand nibble lies in 0..9. They are gated by that condition or by `digit_err`, so invalid codes never trip them. The ripple-adder check holds for any nibble values. The exhaustive sweep stays inside the valid range, and the error-flag scenario drives the invalid codes 10..15. During that scenario only the flag and the operand displays are compared, since the sum is unspecified there.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int DIG_W   = 4;
    localparam int SEG_W   = 7;
    localparam int DEC_MAX = 9;

    localparam logic [SEG_W-1:0] SEG_DARK = 7'h7F;

    typedef struct packed {
        logic             carry;
        logic [DIG_W-1:0] digit;
    } dec_res_t;

    // active-low segment pattern, bit 6 = g ... bit 0 = a
    function automatic logic [SEG_W-1:0] seg_pattern(input logic [DIG_W-1:0] n);
        return (n == 4'd0) ? 7'h40 :
               (n == 4'd1) ? 7'h79 :
               (n == 4'd2) ? 7'h24 :
               (n == 4'd3) ? 7'h30 :
               (n == 4'd4) ? 7'h19 :
               (n == 4'd5) ? 7'h12 :
               (n == 4'd6) ? 7'h02 :
               (n == 4'd7) ? 7'h78 :
               (n == 4'd8) ? 7'h00 :
               (n == 4'd9) ? 7'h10 : SEG_DARK;
    endfunction

endpackage

// File: rtl/bcd_full_adder.sv
module bcd_full_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    logic p;
    assign p    = x ^ y;
    assign s    = p ^ cin;
    assign cout = (x & y) | (p & cin);
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = ci;
    assign co   = c[W];

    for (genvar i = 0; i < W; i++) begin : g_stage
        bcd_full_adder u_fa (
            .x   (a[i]),
            .y   (b[i]),
            .cin (c[i]),
            .s   (s[i]),
            .cout(c[i+1])
        );
    end

    always_comb begin
        // R1
        binary_sum_chk: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}));
    end
endmodule

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_pkg::*;
(
    input  logic [DIG_W-1:0] a,
    input  logic [DIG_W-1:0] b,
    input  logic             ci,
    output dec_res_t         res
);
    logic [DIG_W-1:0] t;
    logic             t_c;
    logic             gt9;
    logic [DIG_W-1:0] adj;
    logic [DIG_W-1:0] fixed;
    logic             fix_c;
    logic             ops_ok;

    bcd_ripple_adder #(.W(DIG_W)) u_sum (
        .a (a),
        .b (b),
        .ci(ci),
        .s (t),
        .co(t_c)
    );

    // above nine: carry set, or 1010..1111 in the low nibble
    assign gt9 = t_c | (t[3] & (t[2] | t[1]));

    // add six (0110) when correcting, zero otherwise
    assign adj = {1'b0, gt9, gt9, 1'b0};

    bcd_ripple_adder #(.W(DIG_W)) u_fix (
        .a (t),
        .b (adj),
        .ci(1'b0),
        .s (fixed),
        .co(fix_c)
    );

    assign res.digit = fixed;
    assign res.carry = gt9;

    assign ops_ok = (a <= DIG_W'(DEC_MAX)) && (b <= DIG_W'(DEC_MAX));

    always_comb begin
        // R1
        digit_range_chk: assert (!ops_ok || res.digit <= DIG_W'(DEC_MAX));
        // R2
        digit_value_chk: assert (!ops_ok ||
            (32'(res.carry) * 10 + 32'(res.digit)) == (32'(a) + 32'(b) + 32'(ci)));
        // R1
        wrap_carry_chk: assert (!(gt9 && !t_c) || fix_c);
    end
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
    import bcd_pkg::*;
(
    input  logic [DIG_W-1:0] nib,
    output logic [SEG_W-1:0] seg
);
    assign seg = seg_pattern(nib);

    always_comb begin
        // R5
        lit_count_chk: assert (nib > DIG_W'(DEC_MAX) || $countones(~seg) >= 2);
    end
endmodule

// File: rtl/bcd_sum_display.sv
module bcd_sum_display
    import bcd_pkg::*;
#(
    parameter int N_DIG = 2
) (
    input  logic [N_DIG*DIG_W-1:0]     a_bcd,
    input  logic [N_DIG*DIG_W-1:0]     b_bcd,
    input  logic                       carry_in,
    output logic [(N_DIG+1)*DIG_W-1:0] sum_bcd,
    output logic                       digit_err,
    output logic [2*N_DIG*SEG_W-1:0]   seg_opnd,
    output logic [(N_DIG+1)*SEG_W-1:0] seg_sum
);
    localparam int N_OPND = 2 * N_DIG;
    localparam int N_SUM  = N_DIG + 1;

    logic [N_DIG:0]            chain;
    dec_res_t [N_DIG-1:0]      cell_res;
    logic [N_OPND*DIG_W-1:0]   opnd_all;
    logic [N_OPND-1:0]         bad_nib;

    assign chain[0] = carry_in;
    assign opnd_all = {b_bcd, a_bcd};

    for (genvar d = 0; d < N_DIG; d++) begin : g_cell
        bcd_digit_cell u_cell (
            .a  (a_bcd[d*DIG_W +: DIG_W]),
            .b  (b_bcd[d*DIG_W +: DIG_W]),
            .ci (chain[d]),
            .res(cell_res[d])
        );
        assign chain[d+1]                = cell_res[d].carry;
        assign sum_bcd[d*DIG_W +: DIG_W] = cell_res[d].digit;
    end

    assign sum_bcd[N_DIG*DIG_W +: DIG_W] = {{(DIG_W-1){1'b0}}, chain[N_DIG]};

    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        assign bad_nib[k] = opnd_all[k*DIG_W +: DIG_W] > DIG_W'(DEC_MAX);
        bcd_seg_decoder u_dec (
            .nib(opnd_all[k*DIG_W +: DIG_W]),
            .seg(seg_opnd[k*SEG_W +: SEG_W])
        );
    end

    assign digit_err = |bad_nib;

    for (genvar k = 0; k < N_SUM; k++) begin : g_sum
        bcd_seg_decoder u_dec (
            .nib(sum_bcd[k*DIG_W +: DIG_W]),
            .seg(seg_sum[k*SEG_W +: SEG_W])
        );
        always_comb begin
            // R3
            sum_digit_chk: assert (digit_err || sum_bcd[k*DIG_W +: DIG_W] <= DIG_W'(DEC_MAX));
            // R7
            sum_lit_chk: assert (digit_err || seg_sum[k*SEG_W +: SEG_W] != SEG_DARK);
        end
    end
endmodule

// File: tb/sim_bcd_sum_display.sv
`timescale 1ns/1ps
module sim_bcd_sum_display;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  a_bcd = 8'h00;
    logic [7:0]  b_bcd = 8'h00;
    logic        carry_in = 1'b0;
    logic [11:0] sum_bcd;
    logic        digit_err;
    logic [27:0] seg_opnd;
    logic [20:0] seg_sum;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [6:0] ref_seg [10];

    always #4 clk = ~clk;

    bcd_sum_display u0 (
        .a_bcd    (a_bcd),
        .b_bcd    (b_bcd),
        .carry_in (carry_in),
        .sum_bcd  (sum_bcd),
        .digit_err(digit_err),
        .seg_opnd (seg_opnd),
        .seg_sum  (seg_sum)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [6:0] exp_seg(input int n);
        return (n >= 0 && n <= 9) ? ref_seg[n] : 7'h7F;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h (a=%h b=%h ci=%0d)",
                     req, act, exp, a_bcd, b_bcd, carry_in);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic ci);
        @(posedge clk);
        a_bcd = a; b_bcd = b; carry_in = ci;
        @(negedge clk);
    endtask

    task automatic check_opnd_segs(input string req);
        for (int k = 0; k < 4; k++) begin
            int v;
            v = (k < 2) ? int'(a_bcd[k*4 +: 4]) : int'(b_bcd[(k-2)*4 +: 4]);
            chk(req, int'(seg_opnd[k*7 +: 7]), int'(exp_seg(v)));
        end
    endtask

    // R8
    task automatic t_zero();
        apply(8'h00, 8'h00, 1'b0);
        chk("R8 sum", int'(sum_bcd), 0);
        chk("R8 err", int'(digit_err), 0);
        chk("R8 seg_opnd", int'(seg_opnd), int'({4{7'h40}}));
        chk("R8 seg_sum", int'(seg_sum), int'({3{7'h40}}));
    endtask

    // R1 R2 R3 R5 R6 R7 over all valid operands, both carries
    task automatic t_sweep();
        for (int x = 0; x < 100; x++) begin
            for (int y = 0; y < 100; y++) begin
                for (int c = 0; c < 2; c++) begin
                    int lo, mid, tot, s0, s1, s2;
                    apply({4'(x / 10), 4'(x % 10)}, {4'(y / 10), 4'(y % 10)}, c[0]);
                    lo  = (x % 10) + (y % 10) + c;
                    mid = (x / 10) + (y / 10) + ((lo >= 10) ? 1 : 0);
                    tot = x + y + c;
                    s0 = tot % 10; s1 = (tot / 10) % 10; s2 = tot / 100;
                    chk("R1 low digit", int'(sum_bcd[3:0]), lo % 10);
                    chk("R2 mid digit", int'(sum_bcd[7:4]), mid % 10);
                    chk("R2 top digit", int'(sum_bcd[11:8]), (mid >= 10) ? 1 : 0);
                    chk("R3 total", int'(sum_bcd), (s2 << 8) | (s1 << 4) | s0);
                    chk("R4 no err", int'(digit_err), 0);
                    chk("R7 seg S0", int'(seg_sum[6:0]),   int'(exp_seg(s0)));
                    chk("R7 seg S1", int'(seg_sum[13:7]),  int'(exp_seg(s1)));
                    chk("R7 seg S2", int'(seg_sum[20:14]), int'(exp_seg(s2)));
                    if ((x % 11) == 0 && c == 0) check_opnd_segs("R6 operand seg");
                end
            end
        end
    endtask

    // R3 extreme
    task automatic t_max();
        apply(8'h99, 8'h99, 1'b1);
        chk("R3 max 199", int'(sum_bcd), 12'h199);
        chk("R5 seg 9", int'(seg_sum[6:0]), 7'h10);
        chk("R5 seg 1", int'(seg_sum[20:14]), 7'h79);
    endtask

    // R4 R6: each nibble position with codes 10..15; 9 does not flag
    task automatic t_err();
        for (int pos = 0; pos < 4; pos++) begin
            for (int v = 9; v < 16; v++) begin
                logic [15:0] ops;
                ops = 16'h5555;
                ops[pos*4 +: 4] = 4'(v);
                apply(ops[7:0], ops[15:8], 1'b0);
                chk("R4 err flag", int'(digit_err), (v > 9) ? 1 : 0);
                chk("R6 dark digit", int'(seg_opnd[pos*7 +: 7]), int'(exp_seg(v)));
            end
        end
    endtask

    // R5 each valid code on every operand slot
    task automatic t_codes();
        for (int v = 0; v < 10; v++) begin
            apply({4'(v), 4'(v)}, {4'(v), 4'(v)}, 1'b0);
            for (int k = 0; k < 4; k++)
                chk("R5 code", int'(seg_opnd[k*7 +: 7]), int'(ref_seg[v]));
        end
    endtask

    initial begin
        ref_seg[0] = 7'h40; ref_seg[1] = 7'h79; ref_seg[2] = 7'h24; ref_seg[3] = 7'h30;
        ref_seg[4] = 7'h19; ref_seg[5] = 7'h12; ref_seg[6] = 7'h02; ref_seg[7] = 7'h78;
        ref_seg[8] = 7'h00; ref_seg[9] = 7'h10;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_zero();
        t_codes();
        t_max();
        t_err();
        t_sweep();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule